// File: doc/BRIEF.md
# Reservation and Conditional-Store Unit

This block holds the one address reservation that a core keeps between a reserving load and a later conditional store. A reserving load hands the block its effective address and the value it read; both are kept. A conditional store presents an address, an access size and the data to write. If the address equals the held reservation, the block issues a compare-and-swap on its memory port, with the held value as the expected word and the store data as the new word. The store succeeds only when memory gives back the expected value. Otherwise it fails at once, with no memory traffic.

Each conditional store ends with a 4-bit condition field for the core, or with an alignment error if its address is not a multiple of its size. An all-ones reservation address marks "no reservation". Every conditional store sets the reservation to that value, and so does any interrupt the core takes. Coherency snooping and arbitration between cores are not part of the block. The memory port is taken to perform the compare-exchange atomically.

Top module: `rsv_unit`

## Requirements
- R1: After reset there is no reservation, and `busy`, `mem_req`, `res_valid` and `align_err` are 0. A conditional store issued before any reserving load fails.
- R2: A reserving load (`lr_valid` while idle) records `lr_addr` and `lr_data`. A later aligned conditional store to the same address raises `mem_req` one cycle after it is taken. At that point `mem_addr` = store address, `mem_size` = store size, `mem_expect` = recorded load data and `mem_new` = store data, and these hold until `mem_ack`.
- R3: An aligned conditional store whose address differs from the reservation, or that finds no reservation, gives `res_valid` one cycle after it is taken with the EQ bit 0. It never raises `mem_req`.
- R4: `res_cr` has this layout. Bit 0 is the summary-overflow input `so_in`, sampled in the cycle the outcome is decided: the cycle the store is taken on a fail without memory access, or the `mem_ack` cycle. Bit 1 is EQ, 1 on success. Bits 3:2 are 0.
- R5: After a compare-and-swap, `res_valid` pulses one cycle after `mem_ack`. EQ is 1 exactly when `mem_old` equals `mem_expect`. `busy` is 1 from the cycle after the store is taken until that result.
- R6: Every conditional store clears the reservation to all-ones, whether it passed, failed or was misaligned. A repeat store to the same address then fails.
- R7: `irq_take` clears the reservation. It takes precedence over a reserving load in the same cycle.
- R8: `sc_size` is log2 of the access size in bytes (0 = byte … 3 = 8 bytes). A conditional store whose address is not a multiple of that size pulses `align_err` one cycle later. It produces no `res_valid` and no `mem_req`. Alignment is checked before the address match.
- R9: While `busy`, `sc_valid` and `lr_valid` are ignored. When both arrive together in the idle state, the conditional store is taken and the reserving load is dropped.
- R10: Because all-ones is the invalid marker, a conditional store to the all-ones address never succeeds, even right after a reserving load to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| so_in | input | 1 | Current summary-overflow bit from the core |
| irq_take | input | 1 | Core is taking an interrupt this cycle |
| lr_valid | input | 1 | Reserving load completed |
| lr_addr | input | AW | Effective address of the reserving load |
| lr_data | input | DW | Value the reserving load read |
| sc_valid | input | 1 | Conditional store request |
| sc_addr | input | AW | Conditional store effective address |
| sc_size | input | 2 | log2 of access size in bytes |
| sc_data | input | DW | Source register value to store |
| busy | output | 1 | Compare-and-swap outstanding |
| mem_req | output | 1 | Compare-exchange request, held until ack |
| mem_addr | output | AW | Compare-exchange address |
| mem_size | output | 2 | Compare-exchange size code |
| mem_expect | output | DW | Expected memory value |
| mem_new | output | DW | Value to write on match |
| mem_ack | input | 1 | Compare-exchange done |
| mem_old | input | DW | Memory value seen by the compare-exchange |
| res_valid | output | 1 | Condition field valid (one-cycle pulse) |
| res_cr | output | 4 | Condition field {0,0,EQ,SO} |
| align_err | output | 1 | Misaligned conditional store (one-cycle pulse) |

## Verification
The bench targets a stale reservation. It retries a store after a pass, after a failure, after a misaligned attempt and after an interrupt. A unit that forgets to invalidate would issue a second compare-and-swap where a plain failure is due. A memory value changed behind the reservation must fail even though the address matches. A design that tests only the address reports success there.

The bench also drives a reserving load and an interrupt in the same cycle, a load and a store in the same cycle, and new requests while a swap is outstanding. A wrong priority or a missing busy guard leaves a live reservation, which the next store exposes. Misaligned stores and stores to the all-ones address check that neither reaches the memory port.

// File: rtl/rsv_unit.sv
module rsv_unit #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          so_in,
  input  logic          irq_take,
  input  logic          lr_valid,
  input  logic [AW-1:0] lr_addr,
  input  logic [DW-1:0] lr_data,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic [1:0]    sc_size,
  input  logic [DW-1:0] sc_data,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_expect,
  output logic [DW-1:0] mem_new,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_old,
  output logic          res_valid,
  output logic [3:0]    res_cr,
  output logic          align_err
);

  localparam logic [AW-1:0] NONE = '1;

  logic [AW-1:0] rsv_addr;
  logic [DW-1:0] rsv_val;
  logic          busy_q;

  logic [AW-1:0] amask;
  logic          misal, hit, take_sc, take_lr;

  assign amask   = (AW'(1) << sc_size) - AW'(1);
  assign misal   = |(sc_addr & amask);
  assign hit     = (sc_addr == rsv_addr) && (sc_addr != NONE);
  assign take_sc = !busy_q && sc_valid;
  assign take_lr = !busy_q && !sc_valid && lr_valid;

  assign busy    = busy_q;
  assign mem_req = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_addr   <= NONE;
      rsv_val    <= '0;
      busy_q     <= 1'b0;
      mem_addr   <= '0;
      mem_size   <= '0;
      mem_expect <= '0;
      mem_new    <= '0;
      res_valid  <= 1'b0;
      res_cr     <= '0;
      align_err  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      align_err <= 1'b0;
      if (take_sc) begin
        rsv_addr <= NONE;
        if (misal) begin
          align_err <= 1'b1;
        end else if (hit) begin
          busy_q     <= 1'b1;
          mem_addr   <= sc_addr;
          mem_size   <= sc_size;
          mem_expect <= rsv_val;
          mem_new    <= sc_data;
        end else begin
          res_valid <= 1'b1;
          res_cr    <= {3'b000, so_in};
        end
      end else if (take_lr) begin
        rsv_addr <= lr_addr;
        rsv_val  <= lr_data;
      end
      if (busy_q && mem_ack) begin
        busy_q    <= 1'b0;
        res_valid <= 1'b1;
        res_cr    <= {2'b00, mem_old == mem_expect, so_in};
      end
      if (irq_take) rsv_addr <= NONE;
    end
  end

  p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_sc && !misal && hit) |=> (mem_req && mem_new == $past(sc_data)
                                    && mem_addr == $past(sc_addr)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_expect)
                               && $stable(mem_new)));

  p_fail_nomem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_sc && !misal && !hit) |=> (res_valid && !res_cr[1] && !mem_req));

  p_cr_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cr[3:2] == 2'b00));

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (res_valid && !mem_req));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_sc |=> (rsv_addr == NONE));

  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (rsv_addr == NONE));

  p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_req && !res_valid));

  p_onepulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, align_err}));

  p_never_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_sc && sc_addr == NONE) |=> !mem_req);

endmodule

// File: tb/test_rsv_unit.sv
module test_rsv_unit;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [AW-1:0] ONES = '1;

  logic clk = 0, rst_n = 0, so_in = 0, irq_take = 0;
  logic lr_valid = 0, sc_valid = 0, mem_ack = 0;
  logic [AW-1:0] lr_addr = '0, sc_addr = '0;
  logic [DW-1:0] lr_data = '0, sc_data = '0, mem_old = '0;
  logic [1:0] sc_size = '0;
  logic busy, mem_req, res_valid, align_err;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [DW-1:0] mem_expect, mem_new;
  logic [3:0] res_cr;

  int checks = 0, fails = 0;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_val;

  always #2 clk = ~clk;

  rsv_unit #(.AW(AW), .DW(DW)) i_rsv_unit (
    .clk(clk), .rst_n(rst_n), .so_in(so_in), .irq_take(irq_take),
    .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_data(lr_data),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_size(sc_size), .sc_data(sc_data),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_expect(mem_expect), .mem_new(mem_new), .mem_ack(mem_ack), .mem_old(mem_old),
    .res_valid(res_valid), .res_cr(res_cr), .align_err(align_err)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic misaligned(input logic [AW-1:0] a, input logic [1:0] sz);
    return (a & ((AW'(1) << sz) - AW'(1))) != '0;
  endfunction

  function automatic logic [3:0] exp_cr(input logic ok, input logic so);
    return {2'b00, ok, so};
  endfunction

  task automatic lr_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic with_irq);
    @(negedge clk);
    lr_valid = 1; lr_addr = a; lr_data = d; irq_take = with_irq;
    @(negedge clk);
    lr_valid = 0; irq_take = 0;
    if (with_irq) m_addr = ONES;
    else begin m_addr = a; m_val = d; end
  endtask

  task automatic irq_op();
    @(negedge clk);
    irq_take = 1;
    @(negedge clk);
    irq_take = 0;
    m_addr = ONES;
  endtask

  task automatic sc_op(input logic [AW-1:0] a, input logic [1:0] sz, input logic [DW-1:0] d,
                       input logic clobber, input logic sov, input int waitc,
                       input logic with_lr);
    logic mis, hit;
    mis = misaligned(a, sz);
    hit = !mis && (a == m_addr) && (a != ONES);
    @(negedge clk);
    sc_valid = 1; sc_addr = a; sc_size = sz; sc_data = d; so_in = sov;
    if (with_lr) begin lr_valid = 1; lr_addr = a ^ 32'h40; lr_data = ~d; end
    @(negedge clk);
    sc_valid = 0; lr_valid = 0;
    if (mis) begin
      check("R8 align_err", align_err, 1);
      check("R8 no res_valid", res_valid, 0);
      check("R8 no mem_req", mem_req, 0);
    end else if (!hit) begin
      check("R3 fail res_valid", res_valid, 1);
      check("R3 no mem_req", mem_req, 0);
      check("R4 fail cr", res_cr, exp_cr(0, sov));
    end else begin
      check("R2 mem_req", mem_req, 1);
      check("R2 mem_addr", mem_addr, a);
      check("R2 mem_size", mem_size, sz);
      check("R2 mem_expect", mem_expect, m_val);
      check("R2 mem_new", mem_new, d);
      check("R5 busy", busy, 1);
      for (int i = 0; i < waitc; i++) begin
        sc_valid = 1; sc_addr = a; sc_size = 0;
        lr_valid = 1; lr_addr = 32'h200; lr_data = 64'h5;
        @(negedge clk);
        check("R9 held mem_req", mem_req, 1);
        check("R9 no early res", res_valid, 0);
        check("R2 hold mem_new", mem_new, d);
      end
      sc_valid = 0; lr_valid = 0;
      mem_ack = 1; mem_old = clobber ? (m_val ^ 64'h1) : m_val;
      @(negedge clk);
      mem_ack = 0;
      check("R5 res_valid", res_valid, 1);
      check("R5 cr", res_cr, exp_cr(!clobber, sov));
      check("R5 idle", mem_req, 0);
    end
    m_addr = ONES;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    m_addr = ONES; m_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 res_valid", res_valid, 0);
    check("R1 align_err", align_err, 0);
    sc_op(32'h100, 3, 64'h1, 0, 0, 0, 0);       // R1: no reservation yet

    lr_op(32'h100, 64'hDEAD_BEEF_0000_1111, 0);  // R2 success path
    sc_op(32'h100, 3, 64'hAAAA, 0, 1, 2, 0);     // R5 with busy wait, R9 ignored
    sc_op(32'h100, 3, 64'hBBBB, 0, 0, 0, 0);     // R6 repeat fails (R9 LR dropped)

    lr_op(32'h108, 64'h77, 0);
    sc_op(32'h108, 3, 64'h88, 1, 0, 0, 0);       // R5 memory changed -> fail
    sc_op(32'h108, 3, 64'h88, 0, 0, 0, 0);       // R6 cleared after failure

    lr_op(32'h110, 64'h9, 0);
    irq_op();
    sc_op(32'h110, 3, 64'h1, 0, 1, 0, 0);        // R7 interrupt cleared

    lr_op(32'h118, 64'h9, 1);
    sc_op(32'h118, 3, 64'h1, 0, 0, 0, 0);        // R7 irq beats load

    lr_op(32'h120, 64'h3, 0);
    sc_op(32'h122, 2, 64'h1, 0, 0, 0, 0);        // R8 misaligned
    sc_op(32'h120, 3, 64'h1, 0, 0, 0, 0);        // R6 cleared by misaligned SC

    lr_op(32'h130, 64'h3, 0);
    sc_op(32'h134, 2, 64'h1, 0, 0, 0, 0);        // R3 mismatch
    sc_op(32'h130, 3, 64'h1, 0, 0, 0, 0);        // R6 mismatch also cleared

    lr_op(32'h140, 64'h3, 0);
    sc_op(32'h140, 3, 64'h5, 0, 0, 0, 1);        // R9 SC wins over same-cycle LR
    sc_op(32'h100, 3, 64'h5, 0, 0, 0, 0);        // R9 dropped LR (addr 0x100) left nothing

    lr_op(ONES, 64'h3, 0);
    sc_op(ONES, 0, 64'h5, 0, 0, 0, 0);           // R10 all-ones never succeeds

    for (int n = 0; n < 400; n++) begin
      int kind;
      logic [AW-1:0] a;
      logic [1:0] sz;
      kind = $urandom % 8;
      a = 32'h1000 + ((($urandom % 4)) << 3);
      sz = 2'($urandom % 4);
      if (($urandom % 5) == 0) a = a + AW'($urandom % 8);
      if (kind < 3) lr_op(a, {$urandom, $urandom}, ($urandom % 6) == 0);
      else if (kind == 3) irq_op();
      else sc_op(a, sz, {$urandom, $urandom}, ($urandom % 3) == 0, 1'($urandom),
                 int'($urandom % 4), ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule